// File: doc/BRIEF.md
# Reciprocal square root estimator

This block returns a coarse first guess of 1/sqrt(x), good to about eight bits, for software or a downstream iteration stage to refine. Two operand kinds are accepted. In float mode the operand is an IEEE single-precision value and the result is a single-precision estimate, with special operands mapped to fixed results and flag pulses. In unsigned mode the 32-bit operand is read as a fixed-point fraction in [0.25, 1) and the result is a fixed-point estimate in [1, 2) with the binary point below bit 31.

The estimate comes from one 256-entry table that is computed from the defining formula when the design elaborates. The table is addressed by one parity bit, which selects the [0.25, 0.5) or [0.5, 1) half of the scaled operand, and the seven mantissa bits that follow the leading one. The block is a short pipeline that accepts one operand per cycle. Its latency is 2 cycles with the default parameters, or 1 cycle when the register in front of the table is left out. A strobe marks each operand on the way in and each result on the way out.

Top module: `rsqrt_est`

## Requirements
- R1: For a scaled operand a, the 8-bit estimate fraction is s - 256, where s = floor(256*r + 0.5). When a < 0.5, r = 1/sqrt((floor(512*a)+0.5)/512). Otherwise r = 1/sqrt((floor(256*a)+0.5)/256). All 256 table entries match this formula.
- R2: Float mode (in_mode = 0) with a finite nonzero positive operand, including a subnormal one whose exponent field is 0:
  - The scaled value is 0.25*(1.m) when the exponent field is odd and 0.5*(1.m) when it is even.
  - The result has sign 0, exponent field floor((380 - e)/2), and mantissa bits [22:15] equal to the estimate fraction, with bits [14:0] zero.
  - No flag is raised.
- R3: Float mode with a quiet NaN operand (exponent all ones, mantissa bit 22 set) returns 0x7FC00000 and raises no flag.
- R4: Float mode with a signalling NaN operand (exponent all ones, mantissa nonzero, bit 22 clear) returns 0x7FC00000 and raises out_invalid.
- R5: Float mode with a zero operand of either sign returns infinity of the same sign (0x7F800000 or 0xFF800000) and raises out_divzero.
- R6: Float mode with a negative operand that is neither zero nor NaN, including negative infinity, returns 0x7FC00000 and raises out_invalid.
- R7: Float mode with positive infinity returns 0x00000000 and raises no flag.
- R8: Unsigned mode (in_mode = 1) with operand bits [31:30] both zero returns 0xFFFFFFFF and raises no flag.
- R9: Unsigned mode with bit 31 or bit 30 set:
  - The scaled value is operand/2^32.
  - The result is bit 31 set, bits [30:23] holding the estimate fraction, and bits [22:0] zero.
  - The float special-value rules do not apply and no flag is raised.
- R10: Each accepted operand (in_valid high at a rising edge) gives exactly one out_valid pulse, 2 cycles later with the default parameters, in input order. out_invalid and out_divzero pulse only together with out_valid and are never both high.
- R11: While rst_n is low, and after its release until the first result, out_valid, out_invalid and out_divzero are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 1 | 0 = single-precision float, 1 = unsigned fixed point |
| in_operand | input | 32 | Operand bits |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Estimate, or the special-value result |
| out_invalid | output | 1 | Invalid-operation pulse |
| out_divzero | output | 1 | Divide-by-zero pulse |

## Verification
The hardest thing to reach from the ports is every one of the 256 table entries with a known, independently computed expectation. In float mode each entry needs its own exponent parity and mantissa, and the result also mixes in the exponent arithmetic. The stimulus therefore walks the table through unsigned mode: bit 31 set with seven swept bits covers the upper half of the scaled range, and bits [31:30] = 01 with seven swept bits covers the lower half. The expected value is computed with real arithmetic on operand/2^32. Float operands then cover both exponent parities, the extreme exponents, a subnormal, and the quiet and signalling NaN distinction, while operands stream back to back.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

   localparam int WORD_W  = 32;
   localparam int FEXP_W  = 8;
   localparam int FMAN_W  = 23;
   localparam int EXP_SUM = 380;

   typedef enum logic [2:0] {
      K_NORMAL = 3'd0,
      K_QNAN   = 3'd1,
      K_SNAN   = 3'd2,
      K_ZERO   = 3'd3,
      K_NEG    = 3'd4,
      K_PINF   = 3'd5,
      K_USAT   = 3'd6,
      K_UFIX   = 3'd7
   } kind_e;

   // Fraction part of the rounded estimate for one table address.
   // The top address bit selects the [0.25,0.5) half of the scaled range.
   // s is the largest integer with (2s-1)^2*(2q+1) <= 2^(3*ew+4) for the
   // lower half, or <= 2^(3*ew+3) for the upper half. This is the integer
   // form of floor(2^ew * r + 0.5).
   function automatic int est_entry(int ew, int addr);
      longint half;
      longint q;
      longint lim;
      longint t;
      int     best;
      half = longint'(1) << (ew - 1);
      q    = half + (longint'(addr) % half);
      lim  = (longint'(addr) >= half) ? (longint'(1) << (3 * ew + 4))
                                      : (longint'(1) << (3 * ew + 3));
      best = 1 << ew;
      for (int k = (1 << ew); k <= (1 << (ew + 1)); k++) begin
         t = 2 * longint'(k) - 1;
         if (t * t * (2 * q + 1) <= lim) best = k;
      end
      return best - (1 << ew);
   endfunction

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
   import rsqrt_pkg::*;
#(
   parameter int EST_W = 8
) (
   input  logic                 mode,
   input  logic [WORD_W-1:0]    operand,
   output kind_e                kind,
   output logic                 sign,
   output logic [FEXP_W-1:0]    exp_out,
   output logic [EST_W-1:0]     idx
);

   localparam int SEL_W = EST_W - 1;

   logic                sgn_f;
   logic [FEXP_W-1:0]   exp_f;
   logic [FMAN_W-1:0]   man_f;
   logic [FEXP_W:0]     exp_diff;
   logic                exp_ones;
   logic                man_zero;

   assign sgn_f    = operand[WORD_W-1];
   assign exp_f    = operand[WORD_W-2 -: FEXP_W];
   assign man_f    = operand[FMAN_W-1:0];
   assign exp_ones = &exp_f;
   assign man_zero = (man_f == '0);
   assign exp_diff = (FEXP_W+1)'(EXP_SUM) - {1'b0, exp_f};

   always_comb begin
      kind    = K_NORMAL;
      sign    = 1'b0;
      exp_out = exp_diff[FEXP_W:1];
      idx     = {exp_f[0], man_f[FMAN_W-1 -: SEL_W]};
      if (mode) begin
         sign = 1'b0;
         if (operand[WORD_W-1 -: 2] == 2'b00) begin
            kind = K_USAT;
            idx  = '0;
         end else if (operand[WORD_W-1]) begin
            kind = K_UFIX;
            idx  = {1'b0, operand[WORD_W-2 -: SEL_W]};
         end else begin
            kind = K_UFIX;
            idx  = {1'b1, operand[WORD_W-3 -: SEL_W]};
         end
      end else begin
         sign = sgn_f;
         if (exp_ones && !man_zero) begin
            kind = man_f[FMAN_W-1] ? K_QNAN : K_SNAN;
         end else if (exp_f == '0 && man_zero) begin
            kind = K_ZERO;
         end else if (sgn_f) begin
            kind = K_NEG;
         end else if (exp_ones) begin
            kind = K_PINF;
         end else begin
            kind = K_NORMAL;
         end
      end
   end

endmodule

// File: rtl/rsqrt_lut.sv
module rsqrt_lut
   import rsqrt_pkg::*;
#(
   parameter int EST_W = 8
) (
   input  logic [EST_W-1:0] addr,
   output logic [EST_W-1:0] frac
);

   localparam int DEPTH = 1 << EST_W;

   logic [EST_W-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      localparam int VAL = est_entry(EST_W, g);
      assign rom[g] = EST_W'(VAL);
   end

   assign frac = rom[addr];

endmodule

// File: rtl/rsqrt_pack.sv
module rsqrt_pack
   import rsqrt_pkg::*;
#(
   parameter int EST_W = 8
) (
   input  kind_e                kind,
   input  logic                 sign,
   input  logic [FEXP_W-1:0]    exp_in,
   input  logic [EST_W-1:0]     frac,
   output logic [WORD_W-1:0]    result,
   output logic                 invalid,
   output logic                 divzero
);

   localparam int FPAD_W = FMAN_W - EST_W;
   localparam int UPAD_W = WORD_W - 1 - EST_W;
   localparam logic [WORD_W-1:0] DEF_NAN = 32'h7FC0_0000;

   always_comb begin
      result  = '0;
      invalid = 1'b0;
      divzero = 1'b0;
      unique case (kind)
         K_NORMAL: result = {1'b0, exp_in, frac, {FPAD_W{1'b0}}};
         K_QNAN:   result = DEF_NAN;
         K_SNAN: begin
            result  = DEF_NAN;
            invalid = 1'b1;
         end
         K_ZERO: begin
            result  = {sign, {FEXP_W{1'b1}}, {FMAN_W{1'b0}}};
            divzero = 1'b1;
         end
         K_NEG: begin
            result  = DEF_NAN;
            invalid = 1'b1;
         end
         K_PINF:   result = '0;
         K_USAT:   result = '1;
         K_UFIX:   result = {1'b1, frac, {UPAD_W{1'b0}}};
         default:  result = '0;
      endcase
   end

endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
   import rsqrt_pkg::*;
#(
   parameter int EST_W      = 8,
   parameter bit REG_LOOKUP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_mode,
   input  logic [31:0]          in_operand,
   output logic                 out_valid,
   output logic [31:0]          out_result,
   output logic                 out_invalid,
   output logic                 out_divzero
);

   if (EST_W < 4 || EST_W > 12) begin : g_bad_est_w
      $error("rsqrt_est: EST_W must lie in 4..12");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("rsqrt_est: word width must be 32");
   end

   kind_e               c_kind;
   logic                c_sign;
   logic [FEXP_W-1:0]   c_exp;
   logic [EST_W-1:0]    c_idx;

   logic                a_valid;
   kind_e               a_kind;
   logic                a_sign;
   logic [FEXP_W-1:0]   a_exp;
   logic [EST_W-1:0]    a_idx;

   logic [EST_W-1:0]    l_frac;
   logic [WORD_W-1:0]   p_result;
   logic                p_invalid;
   logic                p_divzero;

   rsqrt_classify #(.EST_W(EST_W)) u_classify (
      .mode    (in_mode),
      .operand (in_operand),
      .kind    (c_kind),
      .sign    (c_sign),
      .exp_out (c_exp),
      .idx     (c_idx)
   );

   if (REG_LOOKUP) begin : g_stage_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_valid <= 1'b0;
            a_kind  <= K_NORMAL;
            a_sign  <= 1'b0;
            a_exp   <= '0;
            a_idx   <= '0;
         end else begin
            a_valid <= in_valid;
            if (in_valid) begin
               a_kind <= c_kind;
               a_sign <= c_sign;
               a_exp  <= c_exp;
               a_idx  <= c_idx;
            end
         end
      end
   end else begin : g_stage_comb
      assign a_valid = in_valid;
      assign a_kind  = c_kind;
      assign a_sign  = c_sign;
      assign a_exp   = c_exp;
      assign a_idx   = c_idx;
   end

   rsqrt_lut #(.EST_W(EST_W)) u_lut (
      .addr (a_idx),
      .frac (l_frac)
   );

   rsqrt_pack #(.EST_W(EST_W)) u_pack (
      .kind    (a_kind),
      .sign    (a_sign),
      .exp_in  (a_exp),
      .frac    (l_frac),
      .result  (p_result),
      .invalid (p_invalid),
      .divzero (p_divzero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_invalid <= 1'b0;
         out_divzero <= 1'b0;
      end else begin
         out_valid   <= a_valid;
         out_invalid <= a_valid & p_invalid;
         out_divzero <= a_valid & p_divzero;
         if (a_valid) out_result <= p_result;
      end
   end

endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk
   import rsqrt_pkg::*;
#(
   parameter int EST_W = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a_valid,
   input kind_e         a_kind,
   input logic          out_valid,
   input logic [31:0]   out_result,
   input logic          out_invalid,
   input logic          out_divzero
);

   localparam int FLOW = FMAN_W - EST_W;

   // R11: outputs quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r11: assert (!out_valid && !out_invalid && !out_divzero)
            else $error("R11 outputs active during reset");
      end
   end

   // R10: a result leaves exactly one cycle after the lookup stage holds it
   p_stage_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      a_valid |=> out_valid);
   p_stage_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !a_valid |=> !out_valid);
   p_flag_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_invalid || out_divzero) |-> out_valid);
   p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_invalid && out_divzero));

   // R4 / R6: every invalid pulse carries the default NaN
   p_invalid_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> (out_result == 32'h7FC0_0000));

   // R5: divide-by-zero comes with a signed infinity
   p_divzero_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_divzero |-> (out_result[30:0] == 31'h7F80_0000));

   // R2: finite estimates are positive with low mantissa bits clear
   p_normal_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && a_kind == K_NORMAL) |=>
         (!out_result[31] && out_result[FLOW-1:0] == '0 && !out_invalid && !out_divzero));

   // R8: saturated unsigned result
   p_usat_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && a_kind == K_USAT) |=> (out_result == 32'hFFFF_FFFF && !out_invalid));

   // R9: fixed-point result has the leading one and a clean tail
   p_ufix_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && a_kind == K_UFIX) |=>
         (out_result[31] && out_result[30-EST_W:0] == '0 && !out_invalid && !out_divzero));

endmodule

bind rsqrt_est rsqrt_est_chk u_rsqrt_est_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .a_valid     (a_valid),
   .a_kind      (a_kind),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_invalid (out_invalid),
   .out_divzero (out_divzero)
);

// File: tb/test_rsqrt_est.sv
`timescale 1ns/1ps
module test_rsqrt_est;

   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_mode = 1'b0;
   logic [31:0] in_operand = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_invalid;
   logic        out_divzero;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [31:0] q_res [$];
   logic        q_inv [$];
   logic        q_dz  [$];
   int          q_cyc [$];
   string       q_tag [$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rsqrt_est i_rsqrt_est (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_mode     (in_mode),
      .in_operand  (in_operand),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_invalid (out_invalid),
      .out_divzero (out_divzero)
   );

   // Reference formula in real arithmetic (R1)
   function automatic int ref_s(real a);
      real q;
      real r;
      if (a < 0.5) begin
         q = $floor(a * 512.0);
         r = 1.0 / $sqrt((q + 0.5) / 512.0);
      end else begin
         q = $floor(a * 256.0);
         r = 1.0 / $sqrt((q + 0.5) / 256.0);
      end
      return int'($floor(256.0 * r + 0.5));
   endfunction

   task automatic ref_model(input logic mode, input logic [31:0] op,
                            output logic [31:0] res, output logic inv, output logic dz);
      int   e;
      int   s;
      int   ex;
      real  a;
      logic [7:0] f8;
      logic [7:0] e8;
      inv = 1'b0;
      dz  = 1'b0;
      if (mode) begin
         if (op[31:30] == 2'b00) res = 32'hFFFF_FFFF;
         else begin
            a   = real'(op) / 4294967296.0;
            s   = ref_s(a);
            f8  = 8'(s - 256);
            res = {1'b1, f8, 23'd0};
         end
      end else begin
         e = int'(op[30:23]);
         if (e == 255 && op[22:0] != 0) begin
            res = 32'h7FC0_0000;
            inv = !op[22];
         end else if (op[30:0] == 0) begin
            res = {op[31], 31'h7F80_0000};
            dz  = 1'b1;
         end else if (op[31]) begin
            res = 32'h7FC0_0000;
            inv = 1'b1;
         end else if (e == 255) begin
            res = 32'h0;
         end else begin
            a   = (1.0 + real'(op[22:0]) / 8388608.0) * ((e % 2 == 1) ? 0.25 : 0.5);
            s   = ref_s(a);
            ex  = (380 - e) / 2;
            f8  = 8'(s - 256);
            e8  = 8'(ex);
            res = {1'b0, e8, f8, 15'd0};
         end
      end
   endtask

   task automatic drive(input logic mode, input logic [31:0] op, input string tag);
      logic [31:0] r;
      logic        i;
      logic        d;
      ref_model(mode, op, r, i, d);
      @(negedge clk);
      q_res.push_back(r);
      q_inv.push_back(i);
      q_dz.push_back(d);
      q_cyc.push_back(cyc + LAT);
      q_tag.push_back(tag);
      in_valid   = 1'b1;
      in_mode    = mode;
      in_operand = op;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid   = 1'b0;
         in_operand = 32'hDEAD_BEEF;
      end
   endtask

   // Monitor: pop and compare (R10 timing and order)
   always @(negedge clk) begin
      if (rst_n && !out_valid && (out_invalid || out_divzero)) begin
         mismatched++;
         $display("FAIL R10 flag without valid: inv=%0b dz=%0b expected 0/0", out_invalid, out_divzero);
      end
      if (rst_n && out_valid) begin
         if (q_res.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL R10 unexpected result %h, expected none", out_result);
         end else begin
            logic [31:0] er;
            logic        ei;
            logic        ed;
            int          ec;
            string       tg;
            er = q_res.pop_front();
            ei = q_inv.pop_front();
            ed = q_dz.pop_front();
            ec = q_cyc.pop_front();
            tg = q_tag.pop_front();
            compared++;
            if (out_result !== er || out_invalid !== ei || out_divzero !== ed) begin
               mismatched++;
               $display("FAIL %s result=%h inv=%0b dz=%0b expected %h inv=%0b dz=%0b",
                        tg, out_result, out_invalid, out_divzero, er, ei, ed);
            end
            compared++;
            if (cyc != ec) begin
               mismatched++;
               $display("FAIL R10 latency: arrived cycle %0d expected %0d", cyc, ec);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired: pending=%0d expected 0", q_res.size());
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      // R11: reset state
      compared++;
      if (out_valid !== 1'b0 || out_invalid !== 1'b0 || out_divzero !== 1'b0) begin
         mismatched++;
         $display("FAIL R11 in reset valid=%0b inv=%0b dz=%0b expected 0/0/0",
                  out_valid, out_invalid, out_divzero);
      end
      rst_n = 1'b1;
      idle(3);
      compared++;
      if (out_valid !== 1'b0) begin
         mismatched++;
         $display("FAIL R11 after release valid=%0b expected 0", out_valid);
      end

      // R1 / R9: whole table through unsigned mode, back to back
      for (int i = 0; i < 128; i++) begin
         drive(1'b1, {1'b1, 7'(i), 24'hA5C3E1}, "R1 R9 upper half");
         drive(1'b1, {2'b01, 7'(i), 23'h01234}, "R1 R9 lower half");
      end
      idle(4);

      // R8 / R9: unsigned saturation and no float rules
      drive(1'b1, 32'h3FFF_FFFF, "R8 top bits zero");
      drive(1'b1, 32'h0000_0000, "R8 zero operand");
      drive(1'b1, 32'h7FC0_0000, "R9 NaN pattern ignored");
      drive(1'b1, 32'hFFFF_FFFF, "R9 all ones");
      idle(2);

      // R2: normal floats of both parities, extremes and subnormal
      drive(1'b0, 32'h3F80_0000, "R2 one");
      drive(1'b0, 32'h4080_0000, "R2 four");
      drive(1'b0, 32'h4000_0000, "R2 two");
      drive(1'b0, 32'h7F7F_FFFF, "R2 max normal");
      drive(1'b0, 32'h0080_0000, "R2 min normal");
      drive(1'b0, 32'h0000_0001, "R2 subnormal");
      drive(1'b0, 32'h3EFF_FFFF, "R2 mantissa ones");
      idle(1);

      // R3 .. R7: special operands
      drive(1'b0, 32'h7FC0_0001, "R3 quiet NaN");
      drive(1'b0, 32'hFFC0_0000, "R3 negative quiet NaN");
      drive(1'b0, 32'h7F80_0001, "R4 signalling NaN");
      drive(1'b0, 32'h7FA0_0000, "R4 signalling NaN high");
      drive(1'b0, 32'h0000_0000, "R5 positive zero");
      drive(1'b0, 32'h8000_0000, "R5 negative zero");
      drive(1'b0, 32'hBF80_0000, "R6 negative one");
      drive(1'b0, 32'hFF80_0000, "R6 negative infinity");
      drive(1'b0, 32'h8000_0001, "R6 negative subnormal");
      drive(1'b0, 32'h7F80_0000, "R7 positive infinity");
      idle(3);

      // R2: pseudo-random positive floats, mixed with gaps
      lf = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
         lf = lf ^ (lf << 13);
         lf = lf ^ (lf >> 17);
         lf = lf ^ (lf << 5);
         drive(1'b0, {1'b0, lf[30:0]}, "R2 random");
         if (lf[3]) idle(1);
      end
      idle(6);

      compared++;
      if (q_res.size() != 0) begin
         mismatched++;
         $display("FAIL R10 pending results=%0d expected 0", q_res.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule